// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is a small processor control unit whose behaviour is held as microcode in a 128-word by 20-bit read-only control store. A 7-bit control address register selects one microinstruction per clock. Every field of that word acts on the same clock edge. The word drives a datapath with four registers: an 11-bit program counter, an 11-bit address register, a 16-bit data register and a 16-bit accumulator.

Each machine instruction is fetched by a fixed three-word routine that begins at control address 64. The last word of that routine places the opcode bits of the fetched instruction into the middle of the control address. Control then enters a four-word routine for that opcode. No separate instruction register exists: the fetched word stays in the data register, where later microinstructions test its indirect bit.

Each microinstruction is packed, from the most significant bit, as three 3-bit operation fields, a 2-bit condition select, a 2-bit branch kind and a 7-bit target address. The block connects to an external word-addressed memory with 2048 words of 16 bits. That memory returns read data combinationally and writes on the clock edge.

Top module: `useq_top`

## Requirements
- R1: While rst_n is low, the control address is 64 and the PC, address, data, accumulator and return registers are zero. In the first cycle after release, mem_re and mem_we are low and mem_addr is 0.
- R2: Fetch takes three cycles. In the first cycle, PC is copied to the address register. In the second, mem_re is high with mem_addr equal to the PC, the data register captures mem_rdata, and PC increments. In the third, the address register takes data bits 10:0. The next fetch therefore reads address PC+1.
- R3: An instruction word has the indirect bit at 15, the opcode at 14:11 and the address at 10:0. In the third fetch cycle, the control address becomes {0, opcode, 00}, and mem_addr shows the instruction's address field in the following cycle.
- R4: A jump microinstruction loads its target when its condition holds and otherwise steps to the next control address. The condition codes are 00 always, 01 data bit 15, 10 accumulator bit 15, and 11 accumulator equal to zero.
- R5: A call with a true condition saves the next control address and jumps. A return reloads the saved address. Indirect resolution is a shared two-word subroutine that is reached this way.
- R6: Opcode 4 (load) sets the accumulator to M[EA].
- R7: Opcode 1 (add) sets the accumulator to the accumulator plus M[EA], modulo 2^16.
- R8: Opcode 3 (store) writes the accumulator to M[EA]. It raises mem_we for exactly one cycle, with mem_addr equal to EA and mem_wdata equal to the accumulator.
- R9: Opcode 2 (branch) sets the PC to EA when accumulator bit 15 is 1. Otherwise execution continues at the next word; a zero or a positive accumulator does not branch.
- R10: With the indirect bit set, EA is bits 10:0 of M[address field]. This costs one extra memory read before the operand access.
- R11: Opcodes 0 and 5 to 15 change no register apart from the fetch itself and return to fetch, whatever the indirect bit.
- R12: mem_re and mem_we are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 11 | Memory word address (address register) |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle |
| mem_wdata | output | 16 | Memory write data (data register) |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |

## Verification
The hardest situation to reach from the ports is the call into the indirect subroutine and the return from it. That path is visible only as an extra read strobe whose address is a memory word rather than an instruction field. The bench steps an indirect load one cycle at a time from reset. It compares the read strobe and the address in every cycle against a hand-derived trace that spans the map, the call, the return and the start of the next fetch. Conditional skips that go untaken are reached by branching on a negative value and on the largest positive one. Their effect is checked through which stores actually reach memory.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int CA_W        = 7;
  localparam int DATA_W      = 16;
  localparam int ADDR_W      = 11;
  localparam int OPC_W       = 4;
  localparam int FLD_W       = 3;
  localparam int ROM_DEPTH   = 1 << CA_W;
  localparam int UW_W        = 3 * FLD_W + 2 + 2 + CA_W;

  localparam logic [CA_W-1:0] FETCH_ADDR = CA_W'(ROM_DEPTH / 2);
  localparam logic [CA_W-1:0] FETCH_READ = FETCH_ADDR + CA_W'(1);
  localparam logic [CA_W-1:0] FETCH_MAP  = FETCH_ADDR + CA_W'(2);
  localparam logic [CA_W-1:0] INDIR_ADDR = FETCH_ADDR + CA_W'(3);
  localparam logic [CA_W-1:0] INDIR_LAST = FETCH_ADDR + CA_W'(4);

  localparam logic [OPC_W-1:0] OP_ADD = OPC_W'(1);
  localparam logic [OPC_W-1:0] OP_BRN = OPC_W'(2);
  localparam logic [OPC_W-1:0] OP_STO = OPC_W'(3);
  localparam logic [OPC_W-1:0] OP_LDA = OPC_W'(4);

  localparam logic [CA_W-1:0] RB_ADD = CA_W'({OP_ADD, 2'b00});
  localparam logic [CA_W-1:0] RB_BRN = CA_W'({OP_BRN, 2'b00});
  localparam logic [CA_W-1:0] RB_STO = CA_W'({OP_STO, 2'b00});
  localparam logic [CA_W-1:0] RB_LDA = CA_W'({OP_LDA, 2'b00});

  typedef enum logic [FLD_W-1:0] {
    F1_NOP, F1_ADD, F1_CLRAC, F1_INCAC, F1_DRTAC, F1_DRTAR, F1_PCTAR, F1_WRITE
  } f1_e;

  typedef enum logic [FLD_W-1:0] {
    F2_NOP, F2_SUB, F2_OR, F2_AND, F2_READ, F2_ACTDR, F2_INCDR, F2_PCTDR
  } f2_e;

  typedef enum logic [FLD_W-1:0] {
    F3_NOP, F3_XOR, F3_COM, F3_SHL, F3_SHR, F3_INCPC, F3_ARTPC, F3_RSV
  } f3_e;

  typedef enum logic [1:0] {CD_ALWAYS, CD_IND, CD_NEG, CD_ZERO} cd_e;
  typedef enum logic [1:0] {BR_JMP, BR_CALL, BR_RET, BR_MAP} br_e;

  typedef struct packed {
    f1_e             f1;
    f2_e             f2;
    f3_e             f3;
    cd_e             cd;
    br_e             br;
    logic [CA_W-1:0] ad;
  } uword_t;

  function automatic uword_t mk(input f1_e a, input f2_e b, input f3_e c,
                                input cd_e d, input br_e e,
                                input logic [CA_W-1:0] t);
    uword_t w;
    w.f1 = a; w.f2 = b; w.f3 = c; w.cd = d; w.br = e; w.ad = t;
    return w;
  endfunction

  // Control store contents; every unlisted word returns to fetch.
  function automatic uword_t rom_word(input logic [CA_W-1:0] a);
    uword_t w;
    w = mk(F1_NOP, F2_NOP, F3_NOP, CD_ALWAYS, BR_JMP, FETCH_ADDR);
    case (a)
      FETCH_ADDR: w = mk(F1_PCTAR, F2_NOP,  F3_NOP,   CD_ALWAYS, BR_JMP, FETCH_READ);
      FETCH_READ: w = mk(F1_NOP,   F2_READ, F3_INCPC, CD_ALWAYS, BR_JMP, FETCH_MAP);
      FETCH_MAP:  w = mk(F1_DRTAR, F2_NOP,  F3_NOP,   CD_ALWAYS, BR_MAP, '0);
      INDIR_ADDR: w = mk(F1_NOP,   F2_READ, F3_NOP,   CD_ALWAYS, BR_JMP, INDIR_LAST);
      INDIR_LAST: w = mk(F1_DRTAR, F2_NOP,  F3_NOP,   CD_ALWAYS, BR_RET, '0);
      RB_ADD:              w = mk(F1_NOP,   F2_NOP,   F3_NOP,   CD_IND,    BR_CALL, INDIR_ADDR);
      RB_ADD + CA_W'(1):   w = mk(F1_NOP,   F2_READ,  F3_NOP,   CD_ALWAYS, BR_JMP,  RB_ADD + CA_W'(2));
      RB_ADD + CA_W'(2):   w = mk(F1_ADD,   F2_NOP,   F3_NOP,   CD_ALWAYS, BR_JMP,  FETCH_ADDR);
      RB_BRN:              w = mk(F1_NOP,   F2_NOP,   F3_NOP,   CD_NEG,    BR_JMP,  RB_BRN + CA_W'(2));
      RB_BRN + CA_W'(1):   w = mk(F1_NOP,   F2_NOP,   F3_NOP,   CD_ALWAYS, BR_JMP,  FETCH_ADDR);
      RB_BRN + CA_W'(2):   w = mk(F1_NOP,   F2_NOP,   F3_NOP,   CD_IND,    BR_CALL, INDIR_ADDR);
      RB_BRN + CA_W'(3):   w = mk(F1_NOP,   F2_NOP,   F3_ARTPC, CD_ALWAYS, BR_JMP,  FETCH_ADDR);
      RB_STO:              w = mk(F1_NOP,   F2_NOP,   F3_NOP,   CD_IND,    BR_CALL, INDIR_ADDR);
      RB_STO + CA_W'(1):   w = mk(F1_NOP,   F2_ACTDR, F3_NOP,   CD_ALWAYS, BR_JMP,  RB_STO + CA_W'(2));
      RB_STO + CA_W'(2):   w = mk(F1_WRITE, F2_NOP,   F3_NOP,   CD_ALWAYS, BR_JMP,  FETCH_ADDR);
      RB_LDA:              w = mk(F1_NOP,   F2_NOP,   F3_NOP,   CD_IND,    BR_CALL, INDIR_ADDR);
      RB_LDA + CA_W'(1):   w = mk(F1_NOP,   F2_READ,  F3_NOP,   CD_ALWAYS, BR_JMP,  RB_LDA + CA_W'(2));
      RB_LDA + CA_W'(2):   w = mk(F1_DRTAC, F2_NOP,   F3_NOP,   CD_ALWAYS, BR_JMP,  FETCH_ADDR);
      default: ;
    endcase
    return w;
  endfunction

  // Opcode bits of the instruction land in the middle of the control address.
  function automatic logic [CA_W-1:0] map_addr(input logic [DATA_W-1:0] d);
    return CA_W'({d[DATA_W-2 -: OPC_W], 2'b00});
  endfunction

  function automatic logic cond_true(input cd_e cd, input logic [DATA_W-1:0] d,
                                     input logic [DATA_W-1:0] acc);
    logic r;
    case (cd)
      CD_ALWAYS: r = 1'b1;
      CD_IND:    r = d[DATA_W-1];
      CD_NEG:    r = acc[DATA_W-1];
      CD_ZERO:   r = (acc == '0);
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  // Accumulator update; a field-1 operation overrides field 2, which overrides field 3.
  function automatic logic [DATA_W-1:0] ac_next(input f1_e a, input f2_e b, input f3_e c,
                                                input logic [DATA_W-1:0] acc,
                                                input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = acc;
    case (c)
      F3_XOR:  r = acc ^ d;
      F3_COM:  r = ~acc;
      F3_SHL:  r = acc << 1;
      F3_SHR:  r = acc >> 1;
      default: ;
    endcase
    case (b)
      F2_SUB:  r = acc - d;
      F2_OR:   r = acc | d;
      F2_AND:  r = acc & d;
      default: ;
    endcase
    case (a)
      F1_ADD:   r = acc + d;
      F1_CLRAC: r = '0;
      F1_INCAC: r = acc + DATA_W'(1);
      F1_DRTAC: r = d;
      default:  ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
(
  input  logic [CA_W-1:0] addr,
  output uword_t          word
);
  uword_t tbl [ROM_DEPTH];

  for (genvar i = 0; i < ROM_DEPTH; i++) begin : g_word
    assign tbl[i] = rom_word(CA_W'(i));
  end

  assign word = tbl[addr];
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  uword_t            uw,
  input  logic [DATA_W-1:0] dr,
  input  logic [DATA_W-1:0] ac,
  output logic [CA_W-1:0]   car,
  output logic [CA_W-1:0]   sbr,
  output logic              cond
);
  logic [CA_W-1:0] car_inc;
  logic [CA_W-1:0] car_nxt;
  logic            sbr_ld;

  assign cond    = cond_true(uw.cd, dr, ac);
  assign car_inc = car + CA_W'(1);

  always_comb begin
    sbr_ld  = 1'b0;
    car_nxt = car_inc;
    case (uw.br)
      BR_JMP:  car_nxt = cond ? uw.ad : car_inc;
      BR_CALL: begin
        car_nxt = cond ? uw.ad : car_inc;
        sbr_ld  = cond;
      end
      BR_RET:  car_nxt = sbr;
      BR_MAP:  car_nxt = map_addr(dr);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      car <= FETCH_ADDR;
      sbr <= '0;
    end else begin
      car <= car_nxt;
      if (sbr_ld) sbr <= car_inc;
    end
  end
endmodule

// File: rtl/useq_datapath.sv
module useq_datapath
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  uword_t            uw,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ar,
  output logic [DATA_W-1:0] dr,
  output logic [DATA_W-1:0] ac,
  output logic              mem_re,
  output logic              mem_we
);
  logic [DATA_W-1:0] ac_nxt;
  logic [DATA_W-1:0] dr_nxt;
  logic [ADDR_W-1:0] ar_nxt;
  logic [ADDR_W-1:0] pc_nxt;

  assign mem_re = (uw.f2 == F2_READ);
  assign mem_we = (uw.f1 == F1_WRITE);
  assign ac_nxt = ac_next(uw.f1, uw.f2, uw.f3, ac, dr);

  always_comb begin
    dr_nxt = dr;
    case (uw.f2)
      F2_READ:  dr_nxt = mem_rdata;
      F2_ACTDR: dr_nxt = ac;
      F2_INCDR: dr_nxt = dr + DATA_W'(1);
      F2_PCTDR: dr_nxt = {dr[DATA_W-1:ADDR_W], pc};
      default:  ;
    endcase
  end

  always_comb begin
    ar_nxt = ar;
    case (uw.f1)
      F1_DRTAR: ar_nxt = dr[ADDR_W-1:0];
      F1_PCTAR: ar_nxt = pc;
      default:  ;
    endcase
  end

  always_comb begin
    pc_nxt = pc;
    case (uw.f3)
      F3_INCPC: pc_nxt = pc + ADDR_W'(1);
      F3_ARTPC: pc_nxt = ar;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      ar <= '0;
      dr <= '0;
      ac <= '0;
    end else begin
      pc <= pc_nxt;
      ar <= ar_nxt;
      dr <= dr_nxt;
      ac <= ac_nxt;
    end
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re
);
  uword_t            uw;
  logic [CA_W-1:0]   car;
  logic [CA_W-1:0]   sbr;
  logic              cond;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] ar;
  logic [DATA_W-1:0] dr;
  logic [DATA_W-1:0] ac;
  logic [1:0]        br_kind;
  logic [CA_W-1:0]   br_target;

  assign br_kind   = uw.br;
  assign br_target = uw.ad;

  useq_rom u_rom (
    .addr (car),
    .word (uw)
  );

  useq_sequencer u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .uw    (uw),
    .dr    (dr),
    .ac    (ac),
    .car   (car),
    .sbr   (sbr),
    .cond  (cond)
  );

  useq_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .uw        (uw),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .ar        (ar),
    .dr        (dr),
    .ac        (ac),
    .mem_re    (mem_re),
    .mem_we    (mem_we)
  );

  assign mem_addr  = ar;
  assign mem_wdata = dr;
endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CA_W-1:0]   car,
  input logic [CA_W-1:0]   sbr,
  input logic [1:0]        br_kind,
  input logic [CA_W-1:0]   br_target,
  input logic              cond,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] ar,
  input logic [DATA_W-1:0] dr,
  input logic [DATA_W-1:0] ac,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_re,
  input logic              mem_we
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (car == FETCH_ADDR && pc == '0 && ac == '0 && dr == '0));

  p_fetch_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (car == FETCH_ADDR) |=> (car == FETCH_READ && ar == $past(pc)));

  p_fetch_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (car == FETCH_READ) |=> (car == FETCH_MAP && pc == $past(pc) + ADDR_W'(1)
                             && dr == $past(mem_rdata)));

  p_map_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (car == FETCH_MAP) |=> (car == CA_W'({$past(dr[DATA_W-2 -: OPC_W]), 2'b00})
                            && ar == $past(dr[ADDR_W-1:0]) && dr == $past(dr)));

  p_jmp_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'b00 && cond) |=> (car == $past(br_target)));

  p_jmp_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'b00 && !cond) |=> (car == $past(car) + CA_W'(1)));

  p_call_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'b01 && cond) |=> (sbr == $past(car) + CA_W'(1) && car == $past(br_target)));

  p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'b10) |=> (car == $past(sbr)));

  p_store_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == ac));

  p_store_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
endmodule

bind useq_top useq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .car       (car),
  .sbr       (sbr),
  .br_kind   (br_kind),
  .br_target (br_target),
  .cond      (cond),
  .pc        (pc),
  .ar        (ar),
  .dr        (dr),
  .ac        (ac),
  .mem_rdata (mem_rdata),
  .mem_wdata (mem_wdata),
  .mem_re    (mem_re),
  .mem_we    (mem_we)
);

// File: tb/sim_useq_top.sv
`timescale 1ns/1ps
module sim_useq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        mem_re;

  logic [15:0] mem [2048];
  logic        ld_en = 1'b0;
  logic        ld_clr = 1'b0;
  logic [10:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          wr_cnt = 0;
  int          both_cnt = 0;

  always #2 clk = ~clk;

  useq_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (ld_clr) begin
      for (int i = 0; i < 2048; i++) mem[i] <= '0;
    end else if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end else if (rst_n && mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  always @(negedge clk) if (rst_n && mem_re && mem_we) both_cnt <= both_cnt + 1;

  function automatic logic [15:0] ins(input logic i, input logic [3:0] op,
                                      input logic [10:0] a);
    return {i, op, a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic begin_load();
    @(negedge clk);
    rst_n  = 1'b0;
    ld_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ld_clr = 1'b0;
  endtask

  task automatic poke(input logic [10:0] a, input logic [15:0] d);
    ld_addr = a;
    ld_data = d;
    ld_en   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ld_en   = 1'b0;
  endtask

  task automatic release_rst();
    rst_n = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_fetch_trace();
    logic [10:0] ea [9] = '{11'd0, 11'd0, 11'd50, 11'd50, 11'd50,
                            11'd200, 11'd200, 11'd200, 11'd1};
    logic        er [9] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    begin_load();
    poke(11'd0,   ins(1'b1, 4'd4, 11'd50));
    poke(11'd50,  16'd200);
    poke(11'd200, 16'h1234);
    release_rst();
    chk("R1 mem_re after reset", mem_re, 1'b0);
    chk("R1 mem_we after reset", mem_we, 1'b0);
    chk("R1 mem_addr after reset", mem_addr, 11'd0);
    for (int k = 0; k < 9; k++) begin
      step(1);
      chk($sformatf("R2/R3/R5/R10 read strobe cycle %0d", k + 1), mem_re, er[k]);
      chk($sformatf("R2/R3/R5/R10 address cycle %0d", k + 1), mem_addr, ea[k]);
    end
  endtask

  task automatic t_load_add_store();
    int w0;
    begin_load();
    poke(11'd0,   ins(1'b0, 4'd4, 11'd100));
    poke(11'd1,   ins(1'b0, 4'd1, 11'd101));
    poke(11'd2,   ins(1'b0, 4'd3, 11'd102));
    poke(11'd3,   ins(1'b0, 4'd4, 11'd110));
    poke(11'd4,   ins(1'b0, 4'd1, 11'd111));
    poke(11'd5,   ins(1'b0, 4'd3, 11'd112));
    poke(11'd100, 16'hFFF0);
    poke(11'd101, 16'h0025);
    poke(11'd110, 16'h1234);
    poke(11'd111, 16'h1111);
    w0 = wr_cnt;
    release_rst();
    step(16);
    chk("R8 no write before store cycle", mem_we, 1'b0);
    step(1);
    chk("R8 write strobe in store cycle", mem_we, 1'b1);
    chk("R8 write address is EA", mem_addr, 11'd102);
    chk("R7 write data is wrapped sum", mem_wdata, 16'h0015);
    step(1);
    chk("R8 write strobe lasts one cycle", mem_we, 1'b0);
    step(80);
    chk("R6/R7 wrapped sum stored", mem[102], 16'h0015);
    chk("R6/R7 plain sum stored", mem[112], 16'h2345);
    chk("R8 write count", wr_cnt - w0, 2);
  endtask

  task automatic t_indirect();
    begin_load();
    poke(11'd0,   ins(1'b1, 4'd4, 11'd50));
    poke(11'd1,   ins(1'b1, 4'd1, 11'd51));
    poke(11'd2,   ins(1'b1, 4'd3, 11'd52));
    poke(11'd50,  16'd200);
    poke(11'd51,  16'd201);
    poke(11'd52,  16'd300);
    poke(11'd200, 16'h1234);
    poke(11'd201, 16'h0101);
    release_rst();
    step(60);
    chk("R10 indirect store target", mem[300], 16'h1335);
    chk("R10 pointer word untouched", mem[52], 16'd300);
  endtask

  task automatic t_branch(input logic [15:0] v, input logic taken);
    begin_load();
    poke(11'd0,    ins(1'b0, 4'd4, 11'd100));
    poke(11'd1,    ins(1'b0, 4'd2, 11'd1500));
    poke(11'd2,    ins(1'b0, 4'd3, 11'd101));
    poke(11'd1500, ins(1'b0, 4'd3, 11'd102));
    poke(11'd100,  v);
    release_rst();
    step(100);
    chk($sformatf("R9/R4 fall-through store, value %0h", v), mem[101], taken ? 16'h0 : v);
    chk($sformatf("R9/R4 target store, value %0h", v), mem[102], taken ? v : 16'h0);
  endtask

  task automatic t_undefined();
    int w0;
    begin_load();
    poke(11'd0,   ins(1'b0, 4'd4,  11'd100));
    poke(11'd1,   ins(1'b0, 4'd0,  11'd100));
    poke(11'd2,   ins(1'b1, 4'd9,  11'd100));
    poke(11'd3,   ins(1'b0, 4'd15, 11'd100));
    poke(11'd4,   ins(1'b1, 4'd5,  11'd100));
    poke(11'd5,   ins(1'b0, 4'd3,  11'd101));
    poke(11'd100, 16'h5A5A);
    w0 = wr_cnt;
    release_rst();
    step(80);
    chk("R11 accumulator kept across unused opcodes", mem[101], 16'h5A5A);
    chk("R11 operand word untouched", mem[100], 16'h5A5A);
    chk("R11 only the store writes", wr_cnt - w0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_fetch_trace();
    t_load_add_store();
    t_indirect();
    t_branch(16'h8000, 1'b1);
    t_branch(16'h7FFF, 1'b0);
    t_branch(16'h0000, 1'b0);
    t_undefined();
    chk("R12 read and write strobes never together", both_cnt, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule